// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Engine

This block is the bit-level engine on the target side of a single-wire debug link. The link uses one pseudo-open-drain pin with an external pull-up. The host starts every bit time, in both directions, by pulling the pin low. The engine runs on the target bus clock and passes the asynchronous pin through a synchronizer. It treats a detected falling edge as the start of a bit time and counts target cycles from there.

When the engine receives, it never drives the pin. It samples the synchronized level at a fixed cycle of the bit time and reports that level as one bit with a one-cycle strobe. When it transmits, it takes the next bit from its feeder at the start of the bit time:

- For a 0, it holds the pin low for a fixed window.
- For a 1, it adds a one-cycle active-high speed-up pulse so that the rising edge does not depend only on the pull-up.

After each start, a hold-off period sets the earliest moment at which the next bit can begin. Byte framing and command handling sit in the layer above.

Top module: `dbg_bit_engine`

## Requirements
- R1: A falling edge on `pin_in`, seen through a two-flop synchronizer and an edge register, starts a bit time. Cycle 0 of the bit time begins at the third rising clock edge after the pin goes low. Cycle k begins k edges later.
- R2: In receive mode (`mode` = 0), `rx_bit` takes the synchronized pin level present in cycle 10 of the bit time. `rx_valid` is high for exactly one cycle, cycle 11, and is low at all other times.
- R3: During a receive bit time, `pin_oe` stays 0 in every cycle.
- R4: A host low pulse as short as two target cycles is accepted as a valid start of a bit time.
- R5: In transmit mode (`mode` = 1) with a captured bit of 1, `pin_oe` = 1 and `pin_out` = 1 in cycle 7 only. In every other cycle of that bit time, `pin_oe` = 0.
- R6: In transmit mode with a captured bit of 0, `pin_oe` = 1 and `pin_out` = 0 in cycles 0 through 12. From cycle 13 on, `pin_oe` = 0.
- R7: `tx_bit` is captured on the edge that starts a transmit bit time. `tx_ready` is high for exactly one cycle, cycle 0 of that bit time, and is never high for a receive bit time.
- R8: Falling edges detected before cycle 15 of a bit time are ignored. A falling edge detected in cycle 15 or later starts a new bit time, so the earliest next cycle 0 comes 16 cycles after the previous one.
- R9: `mode` is sampled only at the start of a bit time. Changing it during the bit time has no effect on that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous level of the debug pin |
| mode | input | 1 | 0 = receive bit, 1 = transmit bit; sampled at bit start |
| tx_bit | input | 1 | Bit to send in the next transmit bit time |
| tx_ready | output | 1 | One-cycle pulse: tx_bit has been taken |
| rx_bit | output | 1 | Last received bit |
| rx_valid | output | 1 | One-cycle strobe for rx_bit |
| pin_oe | output | 1 | Pin output enable (1 = target drives) |
| pin_out | output | 1 | Pin output value while pin_oe = 1 |

## Verification
The bench places every host edge at a known clock phase. It checks the exact cycle of each strobe and of each drive window:

- Missing one synchronizer stage, or having an extra one, moves `rx_valid` or the drive window by one cycle.
- A speed-up pulse that is too long shows up as more than one driven-high cycle.
- A low window that is one cycle too short shows up as 12 driven cycles instead of 13.

The bench places the second host edge on either side of the hold-off boundary. An off-by-one hold-off either drops the legal second bit or accepts the early one.

The bench also checks that a short two-cycle low pulse starts a bit time. It changes `mode` during a bit time, where a design that reads it live would drive the pin during a receive bit or lose its strobe.

// File: rtl/dbg_bit_pkg.sv
// Shared definitions for the single-wire debug bit engine.
package dbg_bit_pkg;
    // Direction of one bit time, as seen by the target.
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } bit_dir_e;
endpackage

// File: rtl/dbg_pin_sync.sv
// Pin synchronizer and falling-edge detector.
// Assumes pin_i is asynchronous and idles high through an external pull-up.
// Edges are suppressed while the target drives the pin, and for the cycles
// that a driven level needs to travel through the synchronizer.
module dbg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic drive_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic [STAGES:0]   guard_q;

    // Bring the pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Remember recent target drive so that its echo cannot look like a host edge.
    always_ff @(posedge clk) begin
        if (!rst_n) guard_q <= '0;
        else        guard_q <= {guard_q[STAGES-1:0], drive_i};
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~level_o & ~drive_i & ~(|guard_q);

    // R1: an edge report lasts a single cycle.
    a_r1_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/dbg_bit_timer.sv
// Bit-time counter with hold-off and per-bit capture of direction and data.
// Assumes fall_i is a one-cycle pulse per detected host edge.
module dbg_bit_timer
    import dbg_bit_pkg::*;
#(
    parameter int BIT_CYC = 16,
    localparam int CNT_W = $clog2(BIT_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             mode_i,
    input  logic             tx_bit_i,
    output logic             active_o,
    output logic [CNT_W-1:0] cnt_o,
    output bit_dir_e         dir_o,
    output logic             bit_o,
    output logic             tx_ready_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYC - 1);

    logic accept;
    assign accept = fall_i & (~active_o | (cnt_o == LAST));

    // Start, advance and end the bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
        end else if (accept) begin
            active_o <= 1'b1;
            cnt_o    <= '0;
        end else if (active_o) begin
            if (cnt_o == LAST) active_o <= 1'b0;
            else               cnt_o    <= cnt_o + 1'b1;
        end
    end

    // Capture direction and data for the bit that starts, and signal the take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_o      <= DIR_RX;
            bit_o      <= 1'b0;
            tx_ready_o <= 1'b0;
        end else begin
            tx_ready_o <= accept & (mode_i == DIR_TX);
            if (accept) begin
                dir_o <= bit_dir_e'(mode_i);
                bit_o <= tx_bit_i;
            end
        end
    end

    // R8: no restart before the last cycle of a bit time.
    a_r8_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && cnt_o != LAST |=> active_o && cnt_o == $past(cnt_o) + 1'b1);

    // R7: the take strobe is one cycle wide.
    a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |=> !tx_ready_o);
endmodule

// File: rtl/dbg_bit_io.sv
// Pin drive and receive sampling for one bit time.
// Assumes cnt_i counts cycles of the current bit time while active_i is high.
module dbg_bit_io
    import dbg_bit_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int SAMPLE_CYC = 10,
    parameter int PULSE_CYC  = 7,
    parameter int LOW_END    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  bit_dir_e         dir_i,
    input  logic             bit_i,
    input  logic             level_i,
    output logic             pin_oe,
    output logic             pin_out,
    output logic             rx_bit,
    output logic             rx_valid
);
    localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(SAMPLE_CYC);
    localparam logic [CNT_W-1:0] PULSE_AT  = CNT_W'(PULSE_CYC);
    localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_END);

    logic tx_on, drive_low, drive_high;
    assign tx_on      = active_i & (dir_i == DIR_TX);
    assign drive_low  = tx_on & ~bit_i & (cnt_i <= LOW_LAST);
    assign drive_high = tx_on &  bit_i & (cnt_i == PULSE_AT);

    // Combine the two drive windows into enable and value.
    always_comb begin
        pin_oe  = drive_low | drive_high;
        pin_out = drive_high;
    end

    // Sample the pin at the fixed receive cycle and strobe the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_bit   <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= active_i & (dir_i == DIR_RX) & (cnt_i == SAMPLE_AT);
            if (active_i && dir_i == DIR_RX && cnt_i == SAMPLE_AT) rx_bit <= level_i;
        end
    end

    // R3: no drive while the host owns the pin.
    a_r3_quiet_rx: assert property (@(posedge clk) disable iff (!rst_n)
        active_i && dir_i == DIR_RX |-> !pin_oe);

    // R2: the receive strobe is one cycle wide.
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: the speed-up pulse lasts one cycle.
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe && pin_out |=> !(pin_oe && pin_out));

    // R6: the low drive continues through its last cycle.
    a_r6_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe && !pin_out && cnt_i < LOW_LAST |=> pin_oe && !pin_out);
endmodule

// File: rtl/dbg_bit_engine.sv
// Target-side bit engine for a single-wire pseudo-open-drain debug pin.
// Every bit time starts on a host falling edge. Receive bits are sampled at a
// fixed cycle; transmit bits drive a low window (0) or a speed-up pulse (1).
// Assumes pin_in is asynchronous and that the pad combines pin_oe/pin_out.
module dbg_bit_engine
    import dbg_bit_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BIT_CYC     = 16,
    parameter int SAMPLE_CYC  = 10,
    parameter int PULSE_CYC   = 7,
    parameter int LOW_END     = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic mode,
    input  logic tx_bit,
    output logic tx_ready,
    output logic rx_bit,
    output logic rx_valid,
    output logic pin_oe,
    output logic pin_out
);
    localparam int CNT_W = $clog2(BIT_CYC);

    logic             level, fall, active, cur_bit;
    logic [CNT_W-1:0] cnt;
    bit_dir_e         dir;

    dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .drive_i(pin_oe),
        .level_o(level), .fall_o(fall)
    );

    dbg_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .mode_i(mode),
        .tx_bit_i(tx_bit), .active_o(active), .cnt_o(cnt), .dir_o(dir),
        .bit_o(cur_bit), .tx_ready_o(tx_ready)
    );

    dbg_bit_io #(
        .CNT_W(CNT_W), .SAMPLE_CYC(SAMPLE_CYC),
        .PULSE_CYC(PULSE_CYC), .LOW_END(LOW_END)
    ) u_io (
        .clk(clk), .rst_n(rst_n), .active_i(active), .cnt_i(cnt),
        .dir_i(dir), .bit_i(cur_bit), .level_i(level),
        .pin_oe(pin_oe), .pin_out(pin_out), .rx_bit(rx_bit), .rx_valid(rx_valid)
    );

    // R9: a receive bit never strobes together with a take.
    a_r9_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && tx_ready));
endmodule

// File: tb/dbg_bit_engine_test.sv
// Directed bench: each task runs one host scenario and checks the results.
// Index k below is the k-th falling clock edge after the host first pulls low.
module dbg_bit_engine_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, tx_bit = 1'b0, host_low = 1'b0;
    logic tx_ready, rx_bit, rx_valid, pin_oe, pin_out;
    logic pin;
    int n_checks = 0, n_fail = 0;

    int rxv_n, rxv_at1, rxv_at2, oe_n, oe_first, oe_last, hi_n, rdy_n, rdy_at;
    logic rxb1;

    assign pin = pin_oe ? pin_out : ~host_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_bit_engine uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin), .mode(mode), .tx_bit(tx_bit),
        .tx_ready(tx_ready), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sample(input int k);
        if (rx_valid) begin
            rxv_n++;
            if (rxv_n == 1) begin rxv_at1 = k; rxb1 = rx_bit; end
            else rxv_at2 = k;
        end
        if (pin_oe) begin
            oe_n++;
            if (oe_first < 0) oe_first = k;
            oe_last = k;
            if (pin_out) hi_n++;
        end
        if (tx_ready) begin rdy_n++; rdy_at = k; end
    endtask

    // Host low over [0,low_a) and [b0,b1); mode flips at index flip_k.
    task automatic run(input int low_a, input int b0, input int b1, input int n,
                       input logic m0, input int flip_k, input logic tb);
        rxv_n = 0; rxv_at1 = -1; rxv_at2 = -1; rxb1 = 1'bx; oe_n = 0;
        oe_first = -1; oe_last = -1; hi_n = 0; rdy_n = 0; rdy_at = -1;
        mode = m0; tx_bit = tb;
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            if (k >= 1) sample(k);
            host_low = (k < low_a) || (k >= b0 && k < b1);
            if (k == flip_k) mode = ~m0;
        end
        host_low = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 reset pin_oe", int'(pin_oe), 0);
        check("R2 reset rx_valid", int'(rx_valid), 0);
        check("R7 reset tx_ready", int'(tx_ready), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_rx(input logic v);
        run(v ? 4 : 13, 99, 99, 24, 1'b0, -1, 1'b0);
        check("R1 R2 rx_valid cycle", rxv_at1, 14);
        check("R2 rx_valid count", rxv_n, 1);
        check("R2 rx_bit value", int'(rxb1), int'(v));
        check("R3 no drive in rx", oe_n, 0);
        check("R7 no take in rx", rdy_n, 0);
    endtask

    task automatic t_rx_short;
        run(2, 99, 99, 24, 1'b0, -1, 1'b0);
        check("R4 short pulse starts bit", rxv_n, 1);
        check("R4 short pulse rx_valid cycle", rxv_at1, 14);
        check("R4 short pulse rx_bit", int'(rxb1), 1);
    endtask

    task automatic t_tx(input logic v);
        run(3, 99, 99, 24, 1'b1, -1, v);
        check("R7 take cycle", rdy_at, 3);
        check("R7 take count", rdy_n, 1);
        if (v) begin
            check("R5 pulse count", oe_n, 1);
            check("R5 pulse cycle", oe_first, 10);
            check("R5 pulse high", hi_n, 1);
        end else begin
            check("R6 low window length", oe_n, 13);
            check("R6 low window first", oe_first, 3);
            check("R6 low window last", oe_last, 15);
            check("R6 low driven low", hi_n, 0);
        end
        check("R2 no strobe in tx", rxv_n, 0);
    endtask

    task automatic t_holdoff(input int b0, input int exp_n);
        run(3, b0, b0 + 3, 40, 1'b0, -1, 1'b0);
        check("R8 bit count", rxv_n, exp_n);
        check("R8 first strobe", rxv_at1, 14);
        if (exp_n == 2) check("R8 second strobe", rxv_at2, 30);
        else            check("R8 no second strobe", rxv_at2, -1);
    endtask

    task automatic t_mode_flip;
        run(4, 99, 99, 24, 1'b0, 5, 1'b1);
        check("R9 rx kept after flip", rxv_at1, 14);
        check("R9 no drive after flip", oe_n, 0);
        run(3, 99, 99, 24, 1'b1, 5, 1'b1);
        check("R9 tx kept after flip", oe_first, 10);
        check("R9 tx no strobe after flip", rxv_n, 0);
        mode = 1'b0;
    endtask

    initial begin
        t_reset();
        t_rx(1'b1);
        t_rx(1'b0);
        t_rx_short();
        t_tx(1'b1);
        t_tx(1'b0);
        t_holdoff(15, 1);
        t_holdoff(16, 2);
        t_mode_flip();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule